// File: doc/BRIEF.md
# Power-On Configuration Sequencer

This block steers a device from reset to its operating state. Once reset is released it starts on its own. It first clears the configuration memory for a fixed number of cycles. During that time it pulls an open-drain initialisation line low. When clearing ends it lets go of the line. It then waits until the line is sensed high, because any outside agent may keep the line low to hold off configuration.

After the line is seen high, the block accepts a fixed number of configuration words from a valid-qualified word stream. It forwards each accepted word with a running address to the configuration store. After the last word it raises a global set/reset for a single cycle, and after that it raises and holds a completion flag.

A program-request input restarts the whole sequence from any state. While that request is held, the initialisation line stays pulled low.

The open-drain line is modelled as two separate signals: a drive-low enable that goes out of the block and a sensed level that comes into it. Outside the block, the board or bench combines the block's drive with any other agent's drive to form the sensed level.

Top module: `cfgseq_top`

## Requirements
- R1: With `rst_n` low, `init_drive_low` is 1 and `done`, `gsr` and `cfg_we` are 0. After release the sequence starts with no other input activity.
- R2: After reset release, or after the first clock edge that samples `prog_n` high again, `init_drive_low` stays 1 for exactly CLEAR_CYCLES cycles and then goes to 0.
- R3: After clearing, while `init_n_in` is sensed 0, the block stays in its waiting phase. During that phase `cfg_we`, `gsr` and `done` remain 0 even when `data_valid` is 1.
- R4: The first clock edge that sees `init_n_in` at 1 after clearing starts loading. During loading, `cfg_we` equals `data_valid`. Each accepted word appears on `cfg_data`, and `cfg_addr` counts 0, 1, 2 and so on in acceptance order. Idle cycles do not advance the address.
- R5: In the cycle after the LOAD_WORDS-th accepted word, `gsr` is 1 for exactly one cycle, and `done` is still 0 in that cycle.
- R6: `done` rises in the cycle right after the `gsr` pulse and stays 1 until a program request.
- R7: When `prog_n` is sampled 0 in any state, from the next cycle `done` and `gsr` are 0 and `init_drive_low` is 1 for as long as `prog_n` stays 0. While `prog_n` is 0, no word is accepted. On release the full sequence runs again.
- R8: `data_valid` is ignored outside loading: `cfg_we` stays 0 and the address count does not move during clearing, waiting, the `gsr` cycle, the done state and program hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| prog_n | input | 1 | Active-low program request, sampled on the clock |
| init_n_in | input | 1 | Sensed level of the open-drain initialisation line |
| init_drive_low | output | 1 | 1 = block pulls the initialisation line low |
| data_valid | input | 1 | Configuration word on `data_word` is valid |
| data_word | input | DATA_W | Configuration word |
| cfg_we | output | 1 | Word accepted this cycle; write strobe to the configuration store |
| cfg_addr | output | clog2(LOAD_WORDS) | Index of the accepted word |
| cfg_data | output | DATA_W | Accepted word |
| gsr | output | 1 | One-cycle global set/reset pulse |
| done | output | 1 | Configuration finished |

## Verification
A wrong phase or counter value in this block shows at the ports within one cycle. A clear timer that is off by one changes the width of the `init_drive_low` pulse. A word counter that slips shows on `cfg_addr` at the next accepted word. A bad transition shows as `cfg_we` asserted outside loading, or as `gsr` or `done` appearing early, late or twice. The bench sweeps several external hold lengths, several idle-gap patterns in the word stream and several abort points of the program request. It measures each pulse width and each address against arithmetic expectations.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_PROG  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_GSR   = 3'd4,
    ST_DONE  = 3'd5
  } cfg_state_t;

  // Counter width for a count that runs 0 .. limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  // True when a counter value is the final one of its range.
  function automatic logic is_final(input int unsigned value, input int unsigned limit);
    return (value + 1) == limit;
  endfunction

  // Next count value: wraps to zero after the final value.
  function automatic int unsigned step_count(input int unsigned value, input int unsigned limit);
    return is_final(value, limit) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/cfgseq_counter.sv
module cfgseq_counter
  import cfgseq_pkg::*;
#(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CW    = cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          last
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= CW'(step_count(int'(count_q), LIMIT));
    end
  end

  assign count = count_q;
  assign last  = is_final(int'(count_q), LIMIT);

  // R2 and R4: the count never leaves its range
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) < int'(LIMIT));

  // R8: a count that is neither cleared nor stepped holds its value
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count_q));

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic init_n_in,
  input  logic data_valid,
  input  logic clear_last,
  input  logic word_last,
  output logic in_clear,
  output logic in_load,
  output logic accept,
  output logic init_drive_low,
  output logic gsr,
  output logic done
);

  cfg_state_t state_q, state_d;

  // named events for the assertions
  logic ev_prog, ev_clear_end, ev_line_free, ev_load_end;

  assign ev_prog      = !prog_n;
  assign ev_clear_end = (state_q == ST_CLEAR) && clear_last;
  assign ev_line_free = (state_q == ST_WAIT) && init_n_in;
  assign accept       = (state_q == ST_LOAD) && data_valid && prog_n;
  assign ev_load_end  = accept && word_last;

  always_comb begin
    state_d = state_q;
    if (ev_prog) begin
      state_d = ST_PROG;
    end else begin
      unique case (state_q)
        ST_PROG:  state_d = ST_CLEAR;
        ST_CLEAR: if (ev_clear_end) state_d = ST_WAIT;
        ST_WAIT:  if (ev_line_free) state_d = ST_LOAD;
        ST_LOAD:  if (ev_load_end)  state_d = ST_GSR;
        ST_GSR:   state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_PROG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CLEAR;
    else        state_q <= state_d;
  end

  assign in_clear       = (state_q == ST_CLEAR);
  assign in_load        = (state_q == ST_LOAD);
  assign init_drive_low = (state_q == ST_PROG) || (state_q == ST_CLEAR);
  assign gsr            = (state_q == ST_GSR);
  assign done           = (state_q == ST_DONE);

  // R2: clearing ends in the waiting phase unless a program request intervenes
  p_clear_to_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear_end && prog_n) |=> (state_q == ST_WAIT));

  // R3: a line held low keeps the block out of loading
  p_held_line_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !init_n_in) |=> (state_q == ST_WAIT || state_q == ST_PROG));

  // R5: the set/reset pulse lasts one cycle
  p_gsr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> !gsr);

  // R6: done rises only right after the set/reset pulse
  p_done_after_gsr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gsr));

  // R6: done holds until a program request
  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_n) |=> done);

  // R7: a program request drops done and pulls the line low
  p_prog_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (init_drive_low && !done && !gsr));

  // R8: no word is taken unless the line is free and no request is active
  p_accept_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!init_drive_low && !done && !gsr && prog_n));

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int unsigned CLEAR_CYCLES = 64,
  parameter int unsigned LOAD_WORDS   = 256,
  parameter int unsigned DATA_W       = 32,
  localparam int unsigned AW          = cnt_width(LOAD_WORDS),
  localparam int unsigned TW          = cnt_width(CLEAR_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic              init_n_in,
  output logic              init_drive_low,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_word,
  output logic              cfg_we,
  output logic [AW-1:0]     cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              gsr,
  output logic              done
);

  logic          in_clear, in_load, accept;
  logic          clear_last, word_last;
  logic [TW-1:0] clear_cnt;
  logic [AW-1:0] word_cnt;

  cfgseq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_n         (prog_n),
    .init_n_in      (init_n_in),
    .data_valid     (data_valid),
    .clear_last     (clear_last),
    .word_last      (word_last),
    .in_clear       (in_clear),
    .in_load        (in_load),
    .accept         (accept),
    .init_drive_low (init_drive_low),
    .gsr            (gsr),
    .done           (done)
  );

  cfgseq_counter #(.LIMIT(CLEAR_CYCLES), .CW(TW)) u_clear_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_clear),
    .inc   (in_clear),
    .count (clear_cnt),
    .last  (clear_last)
  );

  cfgseq_counter #(.LIMIT(LOAD_WORDS), .CW(AW)) u_word_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_load),
    .inc   (accept),
    .count (word_cnt),
    .last  (word_last)
  );

  assign cfg_we   = accept;
  assign cfg_addr = word_cnt;
  assign cfg_data = data_word;

  // R2: the clear timer is at rest whenever the line is not driven low
  p_clear_timer_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_drive_low |-> (clear_cnt == '0));

  // R4: loading starts with the first address
  p_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_load) |-> (cfg_addr == '0));

endmodule

// File: tb/cfgseq_top_bench.sv
module cfgseq_top_bench;

  localparam int CLR = 5;
  localparam int WDS = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_n = 1'b1;
  logic ext_hold = 1'b0;
  logic data_valid = 1'b0;
  logic [DW-1:0] data_word = '0;
  logic init_n_in, init_drive_low, cfg_we, gsr, done;
  logic [1:0] cfg_addr;
  logic [DW-1:0] cfg_data;

  int checks = 0;
  int fails  = 0;

  // 250 MHz: 4 time units per period
  always #2 clk = ~clk;

  // open-drain line: low when the block or the outside agent pulls it
  assign init_n_in = !(init_drive_low || ext_hold);

  cfgseq_top #(.CLEAR_CYCLES(CLR), .LOAD_WORDS(WDS), .DATA_W(DW)) u_cfgseq_top (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_n_in(init_n_in),
    .init_drive_low(init_drive_low), .data_valid(data_valid), .data_word(data_word),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .gsr(gsr), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int word_of(input int k, input int hold, input int gap);
    return (k * 37 + hold * 11 + gap * 5 + 3) % 256;
  endfunction

  // One configuration pass; entry: the next sample shows the start of clearing.
  task automatic run_seq(input int hold, input int gap, input int abort_at);
    int n = 0;
    ext_hold = (hold > 0);
    while (n < 1000) begin
      @(negedge clk); data_valid = 1'b1; #1;
      if (!init_drive_low) break;
      check("R8", "we during clear", int'(cfg_we), 0);
      n++;
    end
    check("R2", "clear length", n, CLR);
    for (int i = 0; i <= hold; i++) begin
      if (i > 0) begin
        @(negedge clk); ext_hold = (i < hold); data_valid = 1'b1; #1;
      end
      check("R3", "we while waiting", int'(cfg_we), 0);
      check("R3", "gsr while waiting", int'(gsr), 0);
      check("R3", "done while waiting", int'(done), 0);
      check("R3", "line released", int'(init_drive_low), 0);
    end
    for (int k = 0; k < WDS; k++) begin
      if (abort_at == k) begin
        @(negedge clk); prog_n = 1'b0; data_valid = 1'b1; #1;
        check("R7", "we under program request", int'(cfg_we), 0);
        return;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); data_valid = 1'b0; #1;
        check("R4", "we on idle", int'(cfg_we), 0);
      end
      @(negedge clk); data_valid = 1'b1; data_word = DW'(word_of(k, hold, gap)); #1;
      check("R4", "we on valid", int'(cfg_we), 1);
      check("R4", "address", int'(cfg_addr), k);
      check("R4", "data", int'(cfg_data), word_of(k, hold, gap));
      check("R5", "gsr early", int'(gsr), 0);
      check("R6", "done early", int'(done), 0);
    end
    @(negedge clk); data_valid = 1'b1; #1;
    check("R5", "gsr pulse", int'(gsr), 1);
    check("R5", "done with gsr", int'(done), 0);
    check("R8", "we in gsr cycle", int'(cfg_we), 0);
    @(negedge clk); #1;
    check("R5", "gsr width", int'(gsr), 0);
    check("R6", "done rise", int'(done), 1);
    repeat (3) begin
      @(negedge clk); #1;
      check("R6", "done held", int'(done), 1);
      check("R8", "we when done", int'(cfg_we), 0);
    end
  endtask

  task automatic restart(input int hold_cycles);
    @(negedge clk); prog_n = 1'b0; data_valid = 1'b1; #1;
    repeat (hold_cycles) begin
      @(negedge clk); #1;
      check("R7", "line low under request", int'(init_drive_low), 1);
      check("R7", "done dropped", int'(done), 0);
      check("R7", "no gsr", int'(gsr), 0);
      check("R8", "we under request", int'(cfg_we), 0);
    end
    @(negedge clk); prog_n = 1'b1;
  endtask

  initial begin
    data_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "line in reset", int'(init_drive_low), 1);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "gsr in reset", int'(gsr), 0);
    check("R1", "we in reset", int'(cfg_we), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    // R1: the first pass starts with no program request
    run_seq(0, 0, -1);
    for (int hold = 0; hold < 4; hold++) begin
      for (int gap = 0; gap < 3; gap++) begin
        for (int ab = 0; ab < 3; ab++) begin
          restart(1 + ab);
          run_seq(hold, gap, (ab == 0) ? -1 : (ab == 1 ? 0 : 2));
        end
      end
    end
    restart(2);
    run_seq(1, 1, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1 to end of run): actual=%0d cycles expected=fewer", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule